// File: doc/BRIEF.md
# Periodic Interval Timer with Time-of-Day Counter

This block is a bus-mapped interval timer. Software stores a 32-bit reload value, counted in bus-clock cycles, and then writes a control word. That word turns the countdown on and also carries the interrupt vector and priority that go out with each request. While the timer is enabled, it raises a single-cycle request each time the count runs out. It then reloads and starts again, so the timer is periodic with no software help. For one-shot use, software writes zero to the control word after the first request.

Beside the countdown runs a free-running time-of-day counter. It keeps a sub-second nanosecond value and a 64-bit seconds value. Each bus clock it adds the bus period, which is a build parameter and can also be read back. Two vector mappings are available through a parameter. The full mapping presents the programmed 8-bit vector and 4-bit priority as written. The limited mapping can produce only vectors 64 to 127, and it takes the priority from the vector itself.

Top module: `pit_timer`

## Requirements
- R1: After reset the timer is disabled, the remaining count is 0, `irq_req` is low, the time-of-day counter reads 0 seconds and 0 ns, and the control register reads 0.
- R2: Registers are decoded on byte offsets 0x00 control, 0x10 reload, 0x14 remaining count, 0x18 bus period, 0x20 seconds upper word, 0x24 seconds lower word, 0x28 nanoseconds. Only control bits 26 (enable), 23:20 (priority) and 19:12 (vector) are stored. All other control bits read back as zero.
- R3: A control write with bit 26 clear stops the countdown. The remaining count holds, and no request is raised from that edge onward.
- R4: A control write with bit 26 set loads the remaining count from the reload register. With reload N, `irq_req` is high for exactly one cycle N cycles after the load edge, and again every N cycles after that.
- R5: While enabled, the remaining-count register decrements by one per cycle and reloads from the reload register on the cycle the request is raised.
- R6: A reload write made while the timer runs takes effect at the next expiry. A reload of 1 raises a request every cycle. A reload of 0 never raises one.
- R7: With the full mapping, `irq_vec` equals control bits 19:12 and `irq_prio` equals control bits 23:20.
- R8: With the limited mapping, `irq_vec` is 64 plus control bits 17:12, and `irq_prio` is bits 5:2 of that vector. The programmed priority field is ignored.
- R9: The bus-period register reads the build-time period in ns. Writes to offsets 0x14, 0x18, 0x20, 0x24 and 0x28 change nothing.
- R10: Each cycle the nanosecond value grows by the bus period. When the sum reaches 1,000,000,000, that amount is subtracted and the 64-bit seconds value increments.
- R11: Any reload value up to 0xFFFFFFFF is accepted and loaded in full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_req | output | 1 | Single-cycle interrupt request |
| irq_vec | output | 8 | Vector presented with the request |
| irq_prio | output | 4 | Priority presented with the request |

## Verification
The bench builds two copies side by side on the same bus: one with the full vector mapping and one with the limited mapping. This lets R7 and R8 be compared on every cycle against the same programmed fields. Both copies use a bus period of 99,999 ns. That value does not divide one second, so the nanosecond value wraps with a nonzero remainder about every ten thousand cycles. Several second boundaries therefore fall inside a short run, and the subtract-and-carry path of R10 is reached with uneven leftovers.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int DATA_W     = 32;
  localparam int VEC_W      = 8;
  localparam int PRIO_W     = 4;
  localparam int EN_BIT     = 26;
  localparam int PRIO_LSB   = 20;
  localparam int VEC_LSB    = 12;
  localparam int OFF_CTRL   = 'h00;
  localparam int OFF_RELOAD = 'h10;
  localparam int OFF_REMAIN = 'h14;
  localparam int OFF_PERIOD = 'h18;
  localparam int OFF_SECHI  = 'h20;
  localparam int OFF_SECLO  = 'h24;
  localparam int OFF_SUBNS  = 'h28;
  localparam longint NS_PER_SEC = 64'd1_000_000_000;
endpackage

// File: rtl/pit_ctrl_regs.sv
module pit_ctrl_regs
  import pit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_reload,
  input  logic [DATA_W-1:0] wdata,
  output logic              en,
  output logic [VEC_W-1:0]  vec_field,
  output logic [PRIO_W-1:0] prio_field,
  output logic [DATA_W-1:0] reload
);
  logic              en_d;
  logic [VEC_W-1:0]  vec_d;
  logic [PRIO_W-1:0] prio_d;
  logic [DATA_W-1:0] reload_d;

  always_comb begin
    en_d     = en;
    vec_d    = vec_field;
    prio_d   = prio_field;
    reload_d = reload;
    if (wr_ctrl) begin
      en_d   = wdata[EN_BIT];
      vec_d  = wdata[VEC_LSB +: VEC_W];
      prio_d = wdata[PRIO_LSB +: PRIO_W];
    end
    if (wr_reload) reload_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en         <= 1'b0;
      vec_field  <= '0;
      prio_field <= '0;
      reload     <= '0;
    end else begin
      en         <= en_d;
      vec_field  <= vec_d;
      prio_field <= prio_d;
      reload     <= reload_d;
    end
  end
endmodule

// File: rtl/pit_countdown.sv
module pit_countdown
  import pit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_en_bit,
  input  logic              en,
  input  logic [DATA_W-1:0] reload,
  output logic [DATA_W-1:0] count,
  output logic              fire
);
  logic [DATA_W-1:0] count_d;
  logic              fire_d;

  always_comb begin
    count_d = count;
    fire_d  = 1'b0;
    if (wr_ctrl) begin
      if (wr_en_bit) count_d = reload;
    end else if (en) begin
      if (count == DATA_W'(1)) begin
        fire_d  = 1'b1;
        count_d = reload;
      end else if (count != '0) begin
        count_d = count - DATA_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      fire  <= 1'b0;
    end else begin
      count <= count_d;
      fire  <= fire_d;
    end
  end
endmodule

// File: rtl/pit_tod.sv
module pit_tod
  import pit_pkg::*;
#(
  parameter int unsigned PERIOD_NS = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [31:0] ns,
  output logic [63:0] sec
);
  localparam logic [32:0] STEP  = 33'(PERIOD_NS);
  localparam logic [32:0] LIMIT = 33'(NS_PER_SEC);

  logic [32:0] sum;
  logic [31:0] ns_d;
  logic [63:0] sec_d;

  always_comb begin
    sum   = {1'b0, ns} + STEP;
    ns_d  = sum[31:0];
    sec_d = sec;
    if (sum >= LIMIT) begin
      ns_d  = 32'(sum - LIMIT);
      sec_d = sec + 64'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ns  <= '0;
      sec <= '0;
    end else begin
      ns  <= ns_d;
      sec <= sec_d;
    end
  end
endmodule

// File: rtl/pit_timer.sv
module pit_timer
  import pit_pkg::*;
#(
  parameter int          ADDR_W        = 6,
  parameter int unsigned BUS_PERIOD_NS = 10,
  parameter bit          LIMITED_VEC   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_req,
  output logic [7:0]        irq_vec,
  output logic [3:0]        irq_prio
);
  logic              wr_ctrl;
  logic              wr_reload;
  logic              ctrl_en;
  logic [VEC_W-1:0]  vec_field;
  logic [PRIO_W-1:0] prio_field;
  logic [DATA_W-1:0] reload_q;
  logic [DATA_W-1:0] count_q;
  logic [31:0]       ns_q;
  logic [63:0]       sec_q;

  assign wr_ctrl   = bus_we && (bus_addr == ADDR_W'(OFF_CTRL));
  assign wr_reload = bus_we && (bus_addr == ADDR_W'(OFF_RELOAD));

  pit_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_reload(wr_reload),
    .wdata(bus_wdata), .en(ctrl_en), .vec_field(vec_field),
    .prio_field(prio_field), .reload(reload_q)
  );

  pit_countdown u_cnt (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl),
    .wr_en_bit(bus_wdata[EN_BIT]), .en(ctrl_en), .reload(reload_q),
    .count(count_q), .fire(irq_req)
  );

  pit_tod #(.PERIOD_NS(BUS_PERIOD_NS)) u_tod (
    .clk(clk), .rst_n(rst_n), .ns(ns_q), .sec(sec_q)
  );

  generate
    if (LIMITED_VEC) begin : g_limited
      logic [7:0] vec_lim;
      assign vec_lim  = {2'b01, vec_field[5:0]};
      assign irq_vec  = vec_lim;
      assign irq_prio = vec_lim[5:2];
    end else begin : g_full
      assign irq_vec  = vec_field;
      assign irq_prio = prio_field;
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(OFF_CTRL): begin
        bus_rdata[EN_BIT]                 = ctrl_en;
        bus_rdata[PRIO_LSB +: PRIO_W]     = prio_field;
        bus_rdata[VEC_LSB +: VEC_W]       = vec_field;
      end
      ADDR_W'(OFF_RELOAD): bus_rdata = reload_q;
      ADDR_W'(OFF_REMAIN): bus_rdata = count_q;
      ADDR_W'(OFF_PERIOD): bus_rdata = 32'(BUS_PERIOD_NS);
      ADDR_W'(OFF_SECHI):  bus_rdata = sec_q[63:32];
      ADDR_W'(OFF_SECLO):  bus_rdata = sec_q[31:0];
      ADDR_W'(OFF_SUBNS):  bus_rdata = ns_q;
      default:             bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk
  import pit_pkg::*;
#(
  parameter bit LIMITED_VEC = 1'b0
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_ctrl,
  input logic        en,
  input logic [31:0] reload,
  input logic [31:0] count,
  input logic        irq_req,
  input logic [7:0]  irq_vec,
  input logic [3:0]  irq_prio,
  input logic [31:0] ns,
  input logic [63:0] sec
);
  // R3: a stopped timer raises nothing on the next edge
  a_r3_stopped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !irq_req);

  // R5: the count reloads in the cycle the request appears
  a_r5_reload_on_fire: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> count == $past(reload));

  // R5: the count steps down by one while running
  a_r5_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wr_ctrl && count > 32'd1) |=> count == $past(count) - 32'd1);

  // R10: sub-second value stays below one second
  a_r10_ns_range: assert property (@(posedge clk) disable iff (!rst_n)
    64'(ns) < NS_PER_SEC);

  // R10: seconds never jump by more than one
  a_r10_sec_step: assert property (@(posedge clk) disable iff (!rst_n)
    (sec == $past(sec)) || (sec == $past(sec) + 64'd1));

  generate
    if (LIMITED_VEC) begin : g_lim
      // R8: limited mapping stays in 64..127 and priority follows the vector
      a_r8_limited_map: assert property (@(posedge clk) disable iff (!rst_n)
        irq_vec[7:6] == 2'b01 && irq_prio == irq_vec[5:2]);
    end
  endgenerate
endmodule

bind pit_timer pit_timer_chk #(.LIMITED_VEC(LIMITED_VEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .en(ctrl_en),
  .reload(reload_q), .count(count_q), .irq_req(irq_req),
  .irq_vec(irq_vec), .irq_prio(irq_prio), .ns(ns_q), .sec(sec_q)
);

// File: tb/tb_pit_timer.sv
module tb_pit_timer;
  localparam int CLK_PERIOD = 10;
  localparam int PER_NS     = 99_999;
  localparam longint BILLION = 64'd1_000_000_000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_full, rd_lim;
  logic        irq_full, irq_lim;
  logic [7:0]  vec_full, vec_lim;
  logic [3:0]  prio_full, prio_lim;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pit_timer #(.ADDR_W(6), .BUS_PERIOD_NS(PER_NS), .LIMITED_VEC(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rd_full), .irq_req(irq_full), .irq_vec(vec_full), .irq_prio(prio_full));

  pit_timer #(.ADDR_W(6), .BUS_PERIOD_NS(PER_NS), .LIMITED_VEC(1'b1)) dut_lim (
    .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rd_lim), .irq_req(irq_lim), .irq_vec(vec_lim), .irq_prio(prio_lim));

  // behavioural reference
  bit     m_en, m_irq;
  int     m_vf, m_pf;
  longint m_reload, m_count, m_ns, m_sec;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_irq = 0; m_vf = 0; m_pf = 0;
      m_reload = 0; m_count = 0; m_ns = 0; m_sec = 0;
    end else begin
      m_irq = 0;
      if (we && addr == 6'h00) begin
        m_en = wdata[26];
        m_vf = int'(wdata[19:12]);
        m_pf = int'(wdata[23:20]);
        if (m_en) m_count = m_reload;
      end else if (m_en && m_count == 1) begin
        m_irq = 1;
        m_count = m_reload;
      end else if (m_en && m_count > 1) begin
        m_count = m_count - 1;
      end
      if (we && addr == 6'h10) m_reload = longint'(wdata);
      m_ns = m_ns + PER_NS;
      if (m_ns >= BILLION) begin
        m_ns = m_ns - BILLION;
        m_sec = m_sec + 1;
      end
    end
  end

  function automatic logic [31:0] m_read(input logic [5:0] a);
    case (a)
      6'h00: m_read = (32'(m_en) << 26) | (32'(m_pf) << 20) | (32'(m_vf) << 12);
      6'h10: m_read = 32'(m_reload);
      6'h14: m_read = 32'(m_count);
      6'h18: m_read = 32'(PER_NS);
      6'h20: m_read = 32'(m_sec >> 32);
      6'h24: m_read = 32'(m_sec);
      6'h28: m_read = 32'(m_ns);
      default: m_read = 32'd0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison of request, vector and priority (R4, R6, R7, R8)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int lv;
      lv = 64 + (m_vf & 63);
      chk("R4 irq full", 32'(irq_full), 32'(m_irq));
      chk("R7 vec full", 32'(vec_full), 32'(m_vf));
      chk("R7 prio full", 32'(prio_full), 32'(m_pf));
      chk("R4 irq limited", 32'(irq_lim), 32'(m_irq));
      chk("R8 vec limited", 32'(vec_lim), 32'(lv));
      chk("R8 prio limited", 32'(prio_lim), 32'((lv >> 2) & 15));
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; addr = 6'h3c; wdata = '0;
  endtask

  task automatic rd(input string req, input logic [5:0] a);
    @(negedge clk);
    addr = a;
    #1;
    chk(req, rd_full, m_read(a));
    chk(req, rd_lim, m_read(a));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  localparam logic [31:0] EN = 32'h0400_0000;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd("R1 ctrl", 6'h00);
    rd("R1 count", 6'h14);
    rd("R1 ns", 6'h28);
    rd("R1 sec lo", 6'h24);
    chk("R1 irq", 32'(irq_full), 32'd0);
    rd("R9 period", 6'h18);
    // R4, R5, R7, R8 periodic firing
    wr(6'h10, 32'd5);
    wr(6'h00, EN | (32'hA << 20) | (32'hC7 << 12));
    rd("R5 count live", 6'h14);
    rd("R5 count live", 6'h14);
    idle(20);
    rd("R5 count live", 6'h14);
    // R6 reload change while running
    wr(6'h10, 32'd3);
    idle(15);
    rd("R6 reload readback", 6'h10);
    // R3 stop
    wr(6'h00, 32'd0);
    rd("R3 count held", 6'h14);
    idle(10);
    rd("R3 count held", 6'h14);
    // R6 reload of one fires every cycle
    wr(6'h10, 32'd1);
    wr(6'h00, EN | (32'h2 << 20) | (32'h3F << 12));
    idle(6);
    // R6 reload of zero never fires
    wr(6'h10, 32'd0);
    wr(6'h00, EN | (32'h5 << 20) | (32'h81 << 12));
    idle(10);
    rd("R6 zero count", 6'h14);
    // R9 read-only writes ignored
    wr(6'h10, 32'd1000);
    wr(6'h00, EN);
    wr(6'h14, 32'h1234_5678);
    rd("R9 count unchanged", 6'h14);
    wr(6'h18, 32'hFFFF_FFFF);
    rd("R9 period unchanged", 6'h18);
    wr(6'h20, 32'hDEAD_BEEF);
    rd("R9 sec hi unchanged", 6'h20);
    wr(6'h24, 32'h0BAD_F00D);
    rd("R9 sec lo unchanged", 6'h24);
    wr(6'h28, 32'h0000_0007);
    rd("R9 ns unchanged", 6'h28);
    // R11 full-range reload
    wr(6'h10, 32'hFFFF_FFFF);
    wr(6'h00, EN | (32'hF << 20) | (32'hFF << 12));
    rd("R11 count max", 6'h14);
    idle(3);
    rd("R11 count max", 6'h14);
    // R2 unused control bits read zero
    wr(6'h00, 32'hFBFF_FFFF);
    rd("R2 ctrl masked", 6'h00);
    chk("R2 ctrl masked value", rd_full, 32'h00FF_F000);
    wr(6'h00, 32'hFFFF_FFFF);
    rd("R2 ctrl masked", 6'h00);
    // R10 time of day across several second boundaries
    idle(25_000);
    rd("R10 ns", 6'h28);
    rd("R10 sec lo", 6'h24);
    rd("R10 sec hi", 6'h20);
    chk("R10 sec reached", 32'(m_sec >= 2), 32'd1);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150_000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule